// File: doc/BRIEF.md
# Buffered Flash Program Sequencer

This block is the write-side command sequencer for buffered programming of a flash array. A host issues bus write cycles (address, data, strobe). A setup command opens a sequence for one block. The host then polls an availability flag, writes the word count minus one, streams that many words at consecutive addresses, and closes with a confirm cycle addressed anywhere inside the same block. The words are held in a small internal buffer, up to 16 entries by default.

When the confirm is accepted, a modelled program engine takes over. It holds the ready flag low for a fixed, parameterised number of cycles. In its first cycles it presents the buffered words one per cycle on a program port, each with its target address. Lock checking and the supply-fault check are plain inputs sampled at the confirm cycle. Any deviation from the sequence drops the buffered data and raises sticky error flags in the status word, which a clear command resets.

Top module: `pbp_sequencer`

## Requirements
- R1: After reset the status word reads 0x80 (ready, no errors), the extended status word reads 0x00, and `pgm_we_o` is low.
- R2: A write with data low byte 0xE8 while ready sets extended status bit 7 to 1 and opens a sequence for the block holding that address. The same write while the engine is busy sets extended status bit 7 to 0 and opens nothing; the writes that follow it during busy have no effect.
- R3: A count write (N-1) larger than DEPTH-1, or addressed outside the opened block, sets status bits 5 and 4 and discards the sequence, so a later confirm starts no programming.
- R4: After a valid sequence, the engine asserts `pgm_we_o` for exactly N consecutive cycles. It presents word k of the load at address start+k, where start is the address of the first loaded word.
- R5: A data write whose address is outside the opened block, or is not the previous data address plus one, sets status bits 5 and 4 and discards the sequence.
- R6: A closing write whose data low byte is not 0xD0, or whose address is outside the opened block, sets status bits 5 and 4 and starts no programming.
- R7: A valid confirm while `blk_locked_i` is high sets status bit 1 only and starts no programming.
- R8: Status bit 7 (ready) drops in the cycle after an accepted confirm and stays low for exactly BUSY_CYCLES cycles.
- R9: A valid confirm while `supply_fault_i` is high sets status bit 3 only and starts no programming.
- R10: Error bits 5, 4, 3 and 1 are sticky across later sequences. They are cleared only by a write of 0x50 while ready and no sequence is open; a 0x50 write during busy leaves them unchanged.
- R11: The status word layout is bit 7 ready, bit 5 erase/sequence error, bit 4 program/sequence error, bit 3 supply fault, bit 1 protect, and all other bits 0. The extended status word carries availability in bit 7 and 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | DW | Write data; commands use the low byte |
| blk_locked_i | input | 1 | Target block is locked (sampled at confirm) |
| supply_fault_i | input | 1 | Programming supply too low (sampled at confirm) |
| status_o | output | 8 | Status word |
| xstatus_o | output | 8 | Extended status word (availability in bit 7) |
| pgm_we_o | output | 1 | Program engine writes a word this cycle |
| pgm_addr_o | output | AW | Address of the word being programmed |
| pgm_data_o | output | DW | Data of the word being programmed |

## Verification
The bench builds the block with a 12-bit address, 64-word blocks and a 48-cycle engine, and keeps the 16-entry buffer. Small blocks let random start offsets land anywhere, right up to a block edge, and make out-of-block addresses easy to produce. The 48-cycle busy window is long enough to fit a complete rejected setup, count, data and confirm sequence inside it. With a full 16-word buffer, both N=1 and N=16 loads are reachable, as is the first count value that overflows.

// File: rtl/pbp_pkg.sv
package pbp_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_COUNT,
      SQ_LOAD,
      SQ_CONFIRM
   } seq_state_t;

   localparam logic [7:0] CMD_SETUP   = 8'hE8;
   localparam logic [7:0] CMD_CONFIRM = 8'hD0;
   localparam logic [7:0] CMD_CLEAR   = 8'h50;

   typedef struct packed {
      logic erase_err;
      logic prog_err;
      logic supply;
      logic protect;
   } err_flags_t;

endpackage

// File: rtl/pbp_buffer.sv
module pbp_buffer #(
   parameter int  DW          = 16,
   parameter int  DEPTH       = 16,
   parameter bit  RESET_CELLS = 1'b1,
   localparam int IDXW        = $clog2(DEPTH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [IDXW-1:0] wr_idx,
   input  logic [DW-1:0]   wr_data,
   input  logic [IDXW-1:0] rd_idx,
   output logic [DW-1:0]   rd_data
);

   logic [DEPTH-1:0][DW-1:0] cells;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      logic [DW-1:0] cell_q;
      logic          hit;

      assign hit = we && (wr_idx == IDXW'(g));

      if (RESET_CELLS) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cell_q <= '0;
            else if (hit) cell_q <= wr_data;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (hit) cell_q <= wr_data;
         end
      end

      assign cells[g] = cell_q;
   end

   assign rd_data = cells[rd_idx];

endmodule

// File: rtl/pbp_cmd_fsm.sv
module pbp_cmd_fsm
   import pbp_pkg::*;
#(
   parameter int  AW       = 23,
   parameter int  DW       = 16,
   parameter int  DEPTH    = 16,
   parameter int  BLK_BITS = 16,
   localparam int IDXW     = $clog2(DEPTH),
   localparam int BNW      = AW - BLK_BITS
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic [DW-1:0]   wr_data,
   input  logic            eng_busy,
   input  logic            blk_locked,
   input  logic            supply_fault,
   output logic            buf_we,
   output logic [IDXW-1:0] buf_idx,
   output logic            start,
   output logic [AW-1:0]   start_addr,
   output logic [IDXW-1:0] last_idx,
   output err_flags_t      errs,
   output logic            xavail
);

   seq_state_t      state_q;
   logic [BNW-1:0]  blk_q;
   logic [IDXW-1:0] last_q;
   logic [IDXW-1:0] idx_q;
   logic [AW-1:0]   base_q;
   logic [AW-1:0]   next_addr_q;

   logic [7:0] cmd;
   logic       in_blk;
   logic       cnt_fits;
   logic       addr_seq;
   logic       confirm_ok;

   assign cmd        = wr_data[7:0];
   assign in_blk     = (wr_addr[AW-1:BLK_BITS] == blk_q);
   assign cnt_fits   = (wr_data < DW'(DEPTH));
   assign addr_seq   = (idx_q == '0) || (wr_addr == next_addr_q);
   assign confirm_ok = (cmd == CMD_CONFIRM) && in_blk;

   assign buf_we     = wr_en && (state_q == SQ_LOAD) && in_blk && addr_seq;
   assign buf_idx    = idx_q;
   assign start      = wr_en && (state_q == SQ_CONFIRM) && confirm_ok &&
                       !blk_locked && !supply_fault;
   assign start_addr = base_q;
   assign last_idx   = last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= SQ_IDLE;
         blk_q       <= '0;
         last_q      <= '0;
         idx_q       <= '0;
         base_q      <= '0;
         next_addr_q <= '0;
         errs        <= '0;
         xavail      <= 1'b0;
      end else if (wr_en) begin
         unique case (state_q)
            SQ_IDLE: begin
               if (cmd == CMD_SETUP) begin
                  xavail <= !eng_busy;
                  if (!eng_busy) begin
                     blk_q   <= wr_addr[AW-1:BLK_BITS];
                     state_q <= SQ_COUNT;
                  end
               end else if (cmd == CMD_CLEAR && !eng_busy) begin
                  errs <= '0;
               end
            end
            SQ_COUNT: begin
               if (in_blk && cnt_fits) begin
                  last_q  <= wr_data[IDXW-1:0];
                  idx_q   <= '0;
                  state_q <= SQ_LOAD;
               end else begin
                  errs.erase_err <= 1'b1;
                  errs.prog_err  <= 1'b1;
                  state_q        <= SQ_IDLE;
               end
            end
            SQ_LOAD: begin
               if (buf_we) begin
                  if (idx_q == '0) base_q <= wr_addr;
                  next_addr_q <= wr_addr + AW'(1);
                  idx_q       <= idx_q + IDXW'(1);
                  if (idx_q == last_q) state_q <= SQ_CONFIRM;
               end else begin
                  errs.erase_err <= 1'b1;
                  errs.prog_err  <= 1'b1;
                  state_q        <= SQ_IDLE;
               end
            end
            SQ_CONFIRM: begin
               state_q <= SQ_IDLE;
               if (confirm_ok) begin
                  if (blk_locked)        errs.protect <= 1'b1;
                  else if (supply_fault) errs.supply  <= 1'b1;
               end else begin
                  errs.erase_err <= 1'b1;
                  errs.prog_err  <= 1'b1;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pbp_engine.sv
module pbp_engine #(
   parameter int  AW          = 23,
   parameter int  DEPTH       = 16,
   parameter int  BUSY_CYCLES = 64,
   localparam int IDXW        = $clog2(DEPTH),
   localparam int CW          = $clog2(BUSY_CYCLES + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [AW-1:0]   start_addr,
   input  logic [IDXW-1:0] last_idx,
   output logic            busy,
   output logic [IDXW-1:0] rd_idx,
   output logic            pgm_we,
   output logic [AW-1:0]   pgm_addr
);

   logic [CW-1:0]   cnt_q;
   logic [AW-1:0]   base_q;
   logic [IDXW-1:0] last_q;
   logic            busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         base_q <= '0;
         last_q <= '0;
         busy_q <= 1'b0;
      end else if (start && !busy_q) begin
         cnt_q  <= '0;
         base_q <= start_addr;
         last_q <= last_idx;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (cnt_q == CW'(BUSY_CYCLES - 1)) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

   assign busy     = busy_q;
   assign rd_idx   = cnt_q[IDXW-1:0];
   assign pgm_we   = busy_q && (cnt_q <= CW'(last_q));
   assign pgm_addr = base_q + AW'(cnt_q);

endmodule

// File: rtl/pbp_sequencer.sv
module pbp_sequencer
   import pbp_pkg::*;
#(
   parameter int AW          = 23,
   parameter int DW          = 16,
   parameter int DEPTH       = 16,
   parameter int BLK_BITS    = 16,
   parameter int BUSY_CYCLES = 64,
   parameter bit RESET_CELLS = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          blk_locked_i,
   input  logic          supply_fault_i,
   output logic [7:0]    status_o,
   output logic [7:0]    xstatus_o,
   output logic          pgm_we_o,
   output logic [AW-1:0] pgm_addr_o,
   output logic [DW-1:0] pgm_data_o
);

   localparam int IDXW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << IDXW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (DW < 8) begin : g_bad_dw
      $error("DW must hold an 8-bit command");
   end
   if (BLK_BITS < IDXW || BLK_BITS >= AW) begin : g_bad_blk
      $error("BLK_BITS must lie between log2(DEPTH) and AW-1");
   end
   if (BUSY_CYCLES < DEPTH) begin : g_bad_busy
      $error("BUSY_CYCLES must cover one cycle per buffered word");
   end

   logic            buf_we;
   logic [IDXW-1:0] buf_idx;
   logic            start;
   logic [AW-1:0]   start_addr;
   logic [IDXW-1:0] last_idx;
   err_flags_t      errs;
   logic            xavail;
   logic            eng_busy;
   logic [IDXW-1:0] rd_idx;

   pbp_cmd_fsm #(
      .AW(AW), .DW(DW), .DEPTH(DEPTH), .BLK_BITS(BLK_BITS)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .eng_busy(eng_busy), .blk_locked(blk_locked_i), .supply_fault(supply_fault_i),
      .buf_we(buf_we), .buf_idx(buf_idx),
      .start(start), .start_addr(start_addr), .last_idx(last_idx),
      .errs(errs), .xavail(xavail)
   );

   pbp_buffer #(
      .DW(DW), .DEPTH(DEPTH), .RESET_CELLS(RESET_CELLS)
   ) u_buf (
      .clk(clk), .rst_n(rst_n),
      .we(buf_we), .wr_idx(buf_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_data(pgm_data_o)
   );

   pbp_engine #(
      .AW(AW), .DEPTH(DEPTH), .BUSY_CYCLES(BUSY_CYCLES)
   ) u_eng (
      .clk(clk), .rst_n(rst_n),
      .start(start), .start_addr(start_addr), .last_idx(last_idx),
      .busy(eng_busy), .rd_idx(rd_idx),
      .pgm_we(pgm_we_o), .pgm_addr(pgm_addr_o)
   );

   assign status_o  = {!eng_busy, 1'b0, errs.erase_err, errs.prog_err,
                       errs.supply, 1'b0, errs.protect, 1'b0};
   assign xstatus_o = {xavail, 7'b0};

endmodule

// File: rtl/pbp_sequencer_chk.sv
module pbp_sequencer_chk #(
   parameter int AW          = 23,
   parameter int BUSY_CYCLES = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [7:0]    wr_cmd,
   input logic          ready,
   input logic          err_erase,
   input logic          err_prog,
   input logic          protect,
   input logic          xavail,
   input logic          pgm_we,
   input logic [AW-1:0] pgm_addr
);

   int unsigned low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      low_cnt <= 0;
      else if (!ready) low_cnt <= low_cnt + 1;
      else             low_cnt <= 0;
   end

   assert_busy_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && low_cnt == BUSY_CYCLES - 1) |=> ready);

   assert_busy_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> ($past(low_cnt) == BUSY_CYCLES - 1));

   assert_we_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pgm_we |-> !ready);

   assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pgm_we && $past(pgm_we)) |-> (pgm_addr == $past(pgm_addr) + AW'(1)));

   assert_busy_setup_refused_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_cmd == 8'hE8 && !ready) |=> !xavail);

   assert_protect_no_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(protect) |-> ready);

   assert_seq_err_no_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_erase) |-> ready);

   assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_prog) |-> $past(wr_en && wr_cmd == 8'h50 && ready));

endmodule

bind pbp_sequencer pbp_sequencer_chk #(
   .AW(AW), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_data[7:0]),
   .ready(status_o[7]), .err_erase(status_o[5]), .err_prog(status_o[4]),
   .protect(status_o[1]), .xavail(xstatus_o[7]),
   .pgm_we(pgm_we_o), .pgm_addr(pgm_addr_o)
);

// File: tb/pbp_sequencer_bench.sv
`timescale 1ns/1ps
module pbp_sequencer_bench;

   localparam int AW = 12, DW = 16, DEPTH = 16, BLK_BITS = 6, BUSY = 48;
   localparam int BLKW = 1 << BLK_BITS;

   logic          clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          locked = 1'b0, fault = 1'b0;
   logic [7:0]    status_o, xstatus_o;
   logic          pgm_we_o;
   logic [AW-1:0] pgm_addr_o;
   logic [DW-1:0] pgm_data_o;

   always #2.5 clk = ~clk;

   pbp_sequencer #(
      .AW(AW), .DW(DW), .DEPTH(DEPTH), .BLK_BITS(BLK_BITS), .BUSY_CYCLES(BUSY)
   ) u_pbp_sequencer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .blk_locked_i(locked), .supply_fault_i(fault),
      .status_o(status_o), .xstatus_o(xstatus_o),
      .pgm_we_o(pgm_we_o), .pgm_addr_o(pgm_addr_o), .pgm_data_o(pgm_data_o)
   );

   int n_checks = 0, n_errs = 0;
   int cap_n = 0, low_n = 0;
   logic [AW-1:0] cap_addr [32];
   logic [DW-1:0] cap_data [32];
   logic [DW-1:0] words [DEPTH];
   logic [7:0]    exp_err = 8'h00;
   bit            done = 1'b0;

   always @(negedge clk) begin
      if (pgm_we_o && cap_n < 32) begin
         cap_addr[cap_n] = pgm_addr_o;
         cap_data[cap_n] = pgm_data_o;
      end
      if (pgm_we_o) cap_n++;
      if (!status_o[7]) low_n++;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_status(input bit rdy, input logic [7:0] e);
      return {rdy, 7'b0} | e;
   endfunction

   function automatic logic [AW-1:0] blk_addr(input int blk, input int off);
      return AW'(blk * BLKW + off);
   endfunction

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic fill_words(input int n);
      for (int k = 0; k < n; k++) words[k] = DW'($urandom);
   endtask

   task automatic load_seq(input int blk, input int off, input int n,
                           input logic [DW-1:0] conf, input int conf_blk);
      wr(blk_addr(blk, 0), 16'h00E8);
      chk(xstatus_o == 8'h80, "R2 setup accepted", xstatus_o, 8'h80);
      wr(blk_addr(blk, 1), DW'(n - 1));
      for (int k = 0; k < n; k++) wr(blk_addr(blk, off + k), words[k]);
      wr(blk_addr(conf_blk, 3), conf);
   endtask

   task automatic clear_caps();
      cap_n = 0; low_n = 0;
   endtask

   task automatic wait_idle();
      repeat (BUSY + 4) @(negedge clk);
   endtask

   task automatic check_prog(input int blk, input int off, input int n, input string tag);
      chk(cap_n == n, {tag, " R4 word count"}, cap_n, n);
      for (int k = 0; k < n && k < 32; k++) begin
         chk(cap_addr[k] == blk_addr(blk, off + k), {tag, " R4 address"}, cap_addr[k], blk_addr(blk, off + k));
         chk(cap_data[k] == words[k], {tag, " R4 data"}, cap_data[k], words[k]);
      end
      chk(low_n == BUSY, {tag, " R8 busy length"}, low_n, BUSY);
      chk(status_o == exp_status(1'b1, exp_err), {tag, " R11 status after run"}, status_o, exp_status(1'b1, exp_err));
   endtask

   task automatic check_none(input string tag);
      chk(cap_n == 0, {tag, " no programming"}, cap_n, 0);
      chk(low_n == 0, {tag, " ready held"}, low_n, 0);
   endtask

   task automatic good_run(input int blk, input int off, input int n, input string tag);
      fill_words(n);
      clear_caps();
      load_seq(blk, off, n, 16'h00D0, blk);
      wait_idle();
      check_prog(blk, off, n, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_errs++; n_checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 / R11: reset state
      chk(status_o == 8'h80, "R1 reset status", status_o, 8'h80);
      chk(xstatus_o == 8'h00, "R1 reset xstatus", xstatus_o, 8'h00);
      chk(pgm_we_o == 1'b0, "R1 reset pgm_we", pgm_we_o, 0);

      // R4 R8 directed edges: single word, full buffer at block end
      good_run(5, 0, 1, "N=1");
      good_run(9, BLKW - DEPTH, DEPTH, "N=16 edge");

      // random runs
      for (int r = 0; r < 6; r++) begin
         int n, blk, off;
         n   = 1 + int'($urandom % DEPTH);
         blk = int'($urandom % (1 << (AW - BLK_BITS)));
         off = int'($urandom % (BLKW - n + 1));
         good_run(blk, off, n, "random");
      end

      // R2: setup while busy is refused, following writes ignored
      fill_words(4);
      clear_caps();
      load_seq(3, 10, 4, 16'h00D0, 3);
      wr(blk_addr(3, 0), 16'h00E8);
      chk(xstatus_o == 8'h00, "R2 busy setup refused", xstatus_o, 8'h00);
      wr(blk_addr(3, 1), 16'h0000);
      wr(blk_addr(3, 20), 16'h1234);
      wr(blk_addr(3, 3), 16'h00D0);
      wait_idle();
      check_prog(3, 10, 4, "R2 busy");

      // R3: count too large
      clear_caps();
      wr(blk_addr(7, 0), 16'h00E8);
      wr(blk_addr(7, 0), DW'(DEPTH));
      exp_err = 8'h30;
      chk(status_o == exp_status(1'b1, exp_err), "R3 count overflow", status_o, exp_status(1'b1, exp_err));
      wr(blk_addr(7, 0), 16'hBEEF);
      wr(blk_addr(7, 0), 16'h00D0);
      wait_idle();
      check_none("R3");
      wr(blk_addr(7, 0), 16'h0050);
      exp_err = 8'h00;
      chk(status_o == 8'h80, "R10 clear after R3", status_o, 8'h80);

      // R5: skipped address
      clear_caps();
      wr(blk_addr(2, 0), 16'h00E8);
      wr(blk_addr(2, 0), 16'd3);
      wr(blk_addr(2, 4), 16'h1111);
      wr(blk_addr(2, 6), 16'h2222);
      exp_err = 8'h30;
      chk(status_o == exp_status(1'b1, exp_err), "R5 non-sequential", status_o, exp_status(1'b1, exp_err));
      wr(blk_addr(2, 0), 16'h00D0);
      wait_idle();
      check_none("R5 skip");
      wr(blk_addr(2, 0), 16'h0050);
      // R5: data outside block
      clear_caps();
      wr(blk_addr(2, 0), 16'h00E8);
      wr(blk_addr(2, 0), 16'd0);
      wr(blk_addr(4, 0), 16'h3333);
      chk(status_o == exp_status(1'b1, exp_err), "R5 out of block", status_o, exp_status(1'b1, exp_err));
      wait_idle();
      check_none("R5 block");
      wr(blk_addr(2, 0), 16'h0050);
      exp_err = 8'h00;

      // R6: wrong confirm data, then confirm in another block
      fill_words(2);
      clear_caps();
      load_seq(6, 0, 2, 16'h00FF, 6);
      exp_err = 8'h30;
      chk(status_o == exp_status(1'b1, exp_err), "R6 bad confirm", status_o, exp_status(1'b1, exp_err));
      wait_idle();
      check_none("R6 data");
      wr(blk_addr(6, 0), 16'h0050);
      clear_caps();
      load_seq(6, 0, 2, 16'h00D0, 8);
      chk(status_o == exp_status(1'b1, exp_err), "R6 confirm other block", status_o, exp_status(1'b1, exp_err));
      wait_idle();
      check_none("R6 block");
      wr(blk_addr(6, 0), 16'h0050);
      exp_err = 8'h00;

      // R7: locked block, then sticky across a good run (R10)
      locked = 1'b1;
      fill_words(3);
      clear_caps();
      load_seq(1, 5, 3, 16'h00D0, 1);
      exp_err = 8'h02;
      chk(status_o == exp_status(1'b1, exp_err), "R7 protect", status_o, exp_status(1'b1, exp_err));
      wait_idle();
      check_none("R7");
      locked = 1'b0;
      good_run(1, 5, 3, "R10 sticky protect");
      wr(blk_addr(1, 0), 16'h0050);
      exp_err = 8'h00;
      chk(status_o == 8'h80, "R10 clear protect", status_o, 8'h80);

      // R9: supply fault
      fault = 1'b1;
      fill_words(2);
      clear_caps();
      load_seq(11, 0, 2, 16'h00D0, 11);
      fault = 1'b0;
      exp_err = 8'h08;
      chk(status_o == exp_status(1'b1, exp_err), "R9 supply fault", status_o, exp_status(1'b1, exp_err));
      wait_idle();
      check_none("R9");

      // R10: clear during busy is ignored
      fill_words(5);
      clear_caps();
      load_seq(12, 20, 5, 16'h00D0, 12);
      wr(blk_addr(12, 0), 16'h0050);
      chk(status_o == exp_status(1'b0, exp_err), "R10 clear ignored while busy", status_o, exp_status(1'b0, exp_err));
      wait_idle();
      check_prog(12, 20, 5, "R10 busy clear");
      wr(blk_addr(12, 0), 16'h0050);
      exp_err = 8'h00;
      chk(status_o == 8'h80, "R10 final clear", status_o, 8'h80);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

endmodule